// File: doc/BRIEF.md
# Programmable Interrupt Dispatcher

This block gathers eight interrupt sources: four bus interrupt lines, a bus error, a link transaction error, a DMA done event and a DMA fault event. It records each rising edge as a pending bit. Each source has its own enable. A per-source priority field chooses among the pending, enabled sources. A per-source route bit sends a source either to a level-active local interrupt output or to a remote dispatch port. The remote port emits a one-cycle pulse that carries the source number. The transport of that pulse to another node is outside the block.

Software uses a small register port with a write strobe, an address and write data, plus a combinational read data path. Through this port it reads the pending and in-service sets, programs the enables, routes and priorities, and acknowledges sources by writing ones to the pending register. A source sent to the remote side is marked in service, so it is dispatched exactly once per event. It stays marked until software acknowledges it.

Top module: `irqd_top`

## Requirements
- R1: After reset all registers read zero: pending, enable, route, priority and in-service. irq_local_o and remote_pulse_o are low, and local_id_o and remote_id_o are zero.
- R2: A source sampled low and then high at consecutive clock edges sets its pending bit at the edge that samples it high. Holding the source high does not set the bit again after an acknowledgement.
- R3: Writing address 0 clears every pending bit and in-service bit whose write data bit is one. Bits written zero are untouched. A rising edge in the same cycle as the clear leaves the bit set.
- R4: Address 1 holds the enables, with bit i for source i. A disabled source still latches as pending but neither drives irq_local_o nor is dispatched remotely. Enabling it later makes it take part.
- R5: Address 3 holds the priorities, with source i at bits [3i+2:3i]. A larger value wins, and ties go to the lower source index. local_id_o gives the winner among local candidates and is 0 when there is none.
- R6: irq_local_o is high exactly when some source is pending, enabled and routed local (route bit 0).
- R7: Address 2 holds the routes, with 1 meaning remote. A source that is pending, enabled, routed remote and not in service is dispatched one clock after it becomes a candidate. The dispatch is a one-cycle remote_pulse_o with remote_id_o equal to the highest-priority such source. That source becomes in service and is not dispatched again until it is acknowledged.
- R8: Address 4 reads the in-service set, with bit i for source i. Addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 8 | Interrupt source levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_local_o | output | 1 | Local interrupt level |
| local_id_o | output | 3 | Winning local source |
| remote_pulse_o | output | 1 | One-cycle remote dispatch strobe |
| remote_id_o | output | 3 | Source number carried by the remote strobe |

## Verification
A corrupted pending bit shows on irq_local_o or local_id_o in the same cycle, and on the pending read at once. A wrong in-service bit shows one clock later, either as a repeated remote pulse or as a missing one. A wrong priority comparison shows as the wrong local_id_o while several sources are pending together. A lost set-over-clear case shows as a pending bit that reads zero right after the colliding acknowledgement.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    typedef enum logic [2:0] {
        ADDR_PEND  = 3'd0,
        ADDR_EN    = 3'd1,
        ADDR_ROUTE = 3'd2,
        ADDR_PRIO  = 3'd3,
        ADDR_INSVC = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/irqd_regs.sv
module irqd_regs
    import irqd_pkg::*;
#(
    parameter int N  = 8,
    parameter int PW = 3,
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  insvc,
    output logic [N-1:0]  en,
    output logic [N-1:0]  route,
    output logic [N*PW-1:0] prio,
    output logic [N-1:0]  ack,
    output logic [DW-1:0] rdata
);
    typedef struct packed {
        logic [N-1:0]    en;
        logic [N-1:0]    route;
        logic [N*PW-1:0] prio;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        ack   = '0;
        rdata = '0;
        if (we) begin
            case (addr)
                ADDR_PEND:  ack         = wdata[N-1:0];
                ADDR_EN:    cfg_d.en    = wdata[N-1:0];
                ADDR_ROUTE: cfg_d.route = wdata[N-1:0];
                ADDR_PRIO:  cfg_d.prio  = wdata[N*PW-1:0];
                default: ;
            endcase
        end
        case (addr)
            ADDR_PEND:  rdata[N-1:0]    = pend;
            ADDR_EN:    rdata[N-1:0]    = cfg_q.en;
            ADDR_ROUTE: rdata[N-1:0]    = cfg_q.route;
            ADDR_PRIO:  rdata[N*PW-1:0] = cfg_q.prio;
            ADDR_INSVC: rdata[N-1:0]    = insvc;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en    = cfg_q.en;
    assign route = cfg_q.route;
    assign prio  = cfg_q.prio;

    // R4
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_EN) |=> (en == $past(wdata[N-1:0])));
endmodule

// File: rtl/irqd_pending.sv
module irqd_pending #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src,
    input  logic [N-1:0] ack,
    input  logic [N-1:0] grant,
    output logic [N-1:0] pend,
    output logic [N-1:0] insvc
);
    typedef struct packed {
        logic [N-1:0] src;
        logic [N-1:0] pend;
        logic [N-1:0] insvc;
    } pst_t;

    pst_t st_d, st_q;
    logic [N-1:0] rise;

    always_comb begin
        rise        = src & ~st_q.src;
        st_d.src    = src;
        st_d.pend   = (st_q.pend & ~ack) | rise;
        st_d.insvc  = (st_q.insvc & ~ack) | grant;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend  = st_q.pend;
    assign insvc = st_q.insvc;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R2
        src_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[i]) |-> $past(src[i] && !st_q.src[i]));
        // R3
        ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[i] && !rise[i]) |=> !pend[i]);
    end
endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter #(
    parameter int N   = 8,
    parameter int PW  = 3,
    parameter int IDW = 3
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio,
    output logic            valid,
    output logic [IDW-1:0]  id
);
    logic [PW-1:0] best;

    always_comb begin
        valid = 1'b0;
        id    = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!valid || prio[i*PW +: PW] > best)) begin
                valid = 1'b1;
                id    = IDW'(i);
                best  = prio[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/irqd_top.sv
module irqd_top #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_local_o,
    output logic [ID_W-1:0]   local_id_o,
    output logic              remote_pulse_o,
    output logic [ID_W-1:0]   remote_id_o
);
    typedef struct packed {
        logic            pulse;
        logic [ID_W-1:0] id;
    } rst_t;

    rst_t rm_d, rm_q;

    logic [NUM_SRC-1:0] en, route, ack, pend, insvc, grant, lreq, rreq;
    logic [NUM_SRC*PRIO_W-1:0] prio;
    logic            lvalid, rvalid;
    logic [ID_W-1:0] rid;

    irqd_regs #(.N(NUM_SRC), .PW(PRIO_W), .DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .pend(pend), .insvc(insvc), .en(en), .route(route), .prio(prio),
        .ack(ack), .rdata(reg_rdata));

    irqd_pending #(.N(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .src(src_i), .ack(ack), .grant(grant),
        .pend(pend), .insvc(insvc));

    irqd_arbiter #(.N(NUM_SRC), .PW(PRIO_W), .IDW(ID_W)) u_larb (
        .req(lreq), .prio(prio), .valid(lvalid), .id(local_id_o));

    irqd_arbiter #(.N(NUM_SRC), .PW(PRIO_W), .IDW(ID_W)) u_rarb (
        .req(rreq), .prio(prio), .valid(rvalid), .id(rid));

    always_comb begin
        lreq     = pend & en & ~route;
        rreq     = pend & en & route & ~insvc & ~ack;
        grant    = rvalid ? ({{(NUM_SRC-1){1'b0}}, 1'b1} << rid) : '0;
        rm_d.pulse = rvalid;
        rm_d.id    = rvalid ? rid : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rm_q <= '0;
        else        rm_q <= rm_d;
    end

    assign irq_local_o    = lvalid;
    assign remote_pulse_o = rm_q.pulse;
    assign remote_id_o    = rm_q.id;

    // R7
    remote_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remote_pulse_o |=> !(remote_pulse_o && remote_id_o == $past(remote_id_o)));
    // R5
    local_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_local_o |-> (pend[local_id_o] && en[local_id_o] && !route[local_id_o]));
endmodule

// File: tb/tb_irqd_top.sv
module tb_irqd_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_i = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_local_o, remote_pulse_o;
    logic [2:0]  local_id_o, remote_id_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irqd_top dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check((a >= 5) ? "R8 unused addr" : "R1 reset reg", v, 0);
        end
        check("R1 irq_local", {31'd0, irq_local_o}, 0);
        check("R1 remote pulse", {31'd0, remote_pulse_o}, 0);
        check("R1 ids", {26'd0, local_id_o, remote_id_o}, 0);
    endtask

    task automatic t_latch();
        logic [31:0] v;
        wr(3'd1, 32'hFF);
        @(negedge clk); src_i[2] = 1'b1;
        @(negedge clk);
        rd(3'd0, v); check("R2 pending latched", v, 32'h04);
        check("R6 irq_local on", {31'd0, irq_local_o}, 1);
        check("R5 local id", {29'd0, local_id_o}, 2);
        wr(3'd0, 32'h04);
        repeat (2) @(negedge clk);
        rd(3'd0, v); check("R2 held level no relatch", v, 0);
        check("R6 irq_local off", {31'd0, irq_local_o}, 0);
        src_i[2] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        wr(3'd1, 32'hDF);
        @(negedge clk); src_i[5] = 1'b1;
        @(negedge clk); src_i[5] = 1'b0;
        rd(3'd0, v); check("R4 disabled still pending", v, 32'h20);
        check("R4 disabled no irq", {31'd0, irq_local_o}, 0);
        wr(3'd1, 32'hFF);
        check("R4 enable later", {31'd0, irq_local_o}, 1);
        check("R4 id after enable", {29'd0, local_id_o}, 5);
        wr(3'd0, 32'h20);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        wr(3'd3, (32'd2 << 3) | (32'd5 << 9) | (32'd5 << 18));
        rd(3'd3, v); check("R5 prio readback", v, 32'h00140A10);
        @(negedge clk); src_i = 8'h4A;
        @(negedge clk); src_i = 8'h00;
        check("R5 tie lower index", {29'd0, local_id_o}, 3);
        wr(3'd0, 32'h08);
        check("R5 next highest", {29'd0, local_id_o}, 6);
        wr(3'd0, 32'h40);
        check("R5 lowest prio", {29'd0, local_id_o}, 1);
        wr(3'd0, 32'h02);
        check("R6 all cleared", {31'd0, irq_local_o}, 0);
        check("R5 id idle zero", {29'd0, local_id_o}, 0);
    endtask

    task automatic t_remote();
        logic [31:0] v;
        wr(3'd3, (32'd1 << 12) | (32'd6 << 21));
        wr(3'd2, 32'h90);
        @(negedge clk); src_i = 8'h90;
        @(negedge clk); src_i = 8'h00;
        check("R6 remote not local", {31'd0, irq_local_o}, 0);
        check("R7 no pulse yet", {31'd0, remote_pulse_o}, 0);
        @(negedge clk);
        check("R7 first pulse id7", {28'd0, remote_pulse_o, remote_id_o}, 32'hF);
        @(negedge clk);
        check("R7 second pulse id4", {28'd0, remote_pulse_o, remote_id_o}, 32'hC);
        @(negedge clk);
        check("R7 pulse single cycle", {31'd0, remote_pulse_o}, 0);
        rd(3'd4, v); check("R8 in-service", v, 32'h90);
        wr(3'd0, 32'h80);
        rd(3'd4, v); check("R3 insvc cleared", v, 32'h10);
        rd(3'd0, v); check("R3 other pending kept", v, 32'h10);
        @(negedge clk);
        check("R7 no redispatch", {31'd0, remote_pulse_o}, 0);
        wr(3'd0, 32'h10);
        rd(3'd4, v); check("R3 insvc all clear", v, 0);
        wr(3'd2, 32'h00);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        @(negedge clk); src_i[0] = 1'b1;
        @(negedge clk); src_i[0] = 1'b0;
        rd(3'd0, v); check("R2 bit0 set", v, 32'h01);
        @(negedge clk);
        src_i[0] = 1'b1; reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h01;
        @(negedge clk);
        reg_we = 1'b0; src_i[0] = 1'b0;
        rd(3'd0, v); check("R3 set wins over clear", v, 32'h01);
        wr(3'd0, 32'h01);
        rd(3'd0, v); check("R3 final clear", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_disable();
        t_priority();
        t_remote();
        t_collision();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule